// File: doc/BRIEF.md
# Mode-Split Virtually Tagged Cache

This block is a direct-mapped cache that is indexed and tagged with virtual addresses, so its tag check runs alongside address translation rather than after it. Every line can hold instructions or data belonging to either privilege level. Each line carries two valid flags, one for user space and one for supervisor space. A hit requires the tag to match and the flag of the requesting mode to be set.

Invalidation is driven from outside. A pulse on `flush_user` or `flush_super` clears every flag of that mode in a single cycle and leaves the other mode's flags as they were. The control logic raises such a pulse whenever software rewrites the matching segment-table pointer. Turning the enable input off and then on again clears every flag of both modes. While the enable is low, lookups always miss and fills are dropped. A fill that carries the cache-inhibit flag from its translated page entry is also dropped. The backing memory and the translation logic sit outside the block: the fill port receives whole lines, and the inhibit flag arrives together with the fill.

Capacity is a parameter. The default is 16 KB, and 32 KB is the other intended setting. Lines are 16 bytes.

Top module: `mode_split_vcache`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, rsp_valid and rsp_hit are 0 and no line is valid in either mode.
- R2: A lookup (acc_valid high at an edge) gives rsp_valid high after that edge and only then. rsp_data is word acc_vaddr[3:2] of the line, where word 0 is bits 31:0. On a miss, rsp_data is 0.
- R3: The line index is vaddr[IDX_W+3:4]. The tag is vaddr[31:IDX_W+4]. A lookup whose tag differs from the stored tag misses.
- R4: A lookup hits only if the valid flag of its own mode is set at that index. acc_super=1 selects supervisor mode and acc_super=0 selects user mode.
- R5: A fill (fill_valid high, cache_en high, fill_inhibit low) stores the tag and the line. It sets the flag of the mode given by fill_super and clears the other mode's flag at that index.
- R6: A fill with fill_inhibit high changes nothing. A later lookup to that address still misses.
- R7: flush_user clears every user flag. Supervisor flags are kept.
- R8: flush_super clears every supervisor flag. User flags are kept.
- R9: While cache_en is low, every lookup misses and every fill is ignored.
- R10: When cache_en is high at an edge after being low at the previous edge, every flag of both modes is cleared.
- R11: A lookup sees the contents as they were before the fills and flushes of the same edge. A flush or full invalidation at the same edge as a fill wins for the mode it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache enable level; a low-to-high change invalidates everything |
| flush_user | input | 1 | Pulse: clear all user-mode valid flags |
| flush_super | input | 1 | Pulse: clear all supervisor-mode valid flags |
| acc_valid | input | 1 | Lookup request |
| acc_vaddr | input | 32 | Lookup virtual address |
| acc_super | input | 1 | Lookup mode: 1 supervisor, 0 user |
| fill_valid | input | 1 | Line fill request |
| fill_vaddr | input | 32 | Fill virtual address |
| fill_super | input | 1 | Fill mode: 1 supervisor, 0 user |
| fill_inhibit | input | 1 | Cache-inhibit flag of the page; suppresses allocation |
| fill_line | input | 128 | Line data, word 0 in bits 31:0 |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | 32 | Selected word on a hit, zero on a miss |

## Verification
Directed sequences place user and supervisor lines at the same index and address them with equal and with differing tags. This separates a mode-flag fault from a tag-compare fault. Each flush pulse, and each disable/enable toggle, is followed by lookups in both modes, so a flush that clears too much is told apart from one that clears too little. Coincident lookups, fills and flushes at one edge expose ordering errors. A long random phase mixes all inputs over a small address set, which gives frequent hits and conflicts, and compares every response with a behavioural model.

// File: rtl/mode_split_vcache_pkg.sv
package mode_split_vcache_pkg;
    localparam int WORD_W = 32;

    typedef enum logic {
        MODE_USER  = 1'b0,
        MODE_SUPER = 1'b1
    } priv_mode_e;
endpackage

// File: rtl/mode_split_vcache_valid.sv
module mode_split_vcache_valid #(
    parameter int LINES = 1024,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_super,
    input  logic             flush_user,
    input  logic             flush_super,
    input  logic             flush_all,
    output logic [LINES-1:0] valid_user,
    output logic [LINES-1:0] valid_super
);
    import mode_split_vcache_pkg::*;

    typedef struct packed {
        logic [LINES-1:0] usr;
        logic [LINES-1:0] sup;
    } vflags_t;

    vflags_t flags_d, flags_q;
    priv_mode_e fill_mode;

    assign fill_mode = priv_mode_e'(fill_super);

    always_comb begin
        flags_d = flags_q;
        if (fill_we) begin
            if (fill_mode == MODE_SUPER) begin
                flags_d.sup[fill_idx] = 1'b1;
                flags_d.usr[fill_idx] = 1'b0;
            end else begin
                flags_d.usr[fill_idx] = 1'b1;
                flags_d.sup[fill_idx] = 1'b0;
            end
        end
        if (flush_all || flush_user)  flags_d.usr = '0;
        if (flush_all || flush_super) flags_d.sup = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign valid_user  = flags_q.usr;
    assign valid_super = flags_q.sup;

    a_r7_user_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_user |=> valid_user == '0);

    a_r8_super_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_super |=> valid_super == '0);

    a_r10_toggle_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_user == '0 && valid_super == '0));

    a_r5_user_fill_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && !fill_super && !flush_user && !flush_all)
        |=> (valid_user[$past(fill_idx)] && !valid_super[$past(fill_idx)]));

    a_r5_super_fill_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && fill_super && !flush_super && !flush_all)
        |=> (valid_super[$past(fill_idx)] && !valid_user[$past(fill_idx)]));
endmodule

// File: rtl/mode_split_vcache_store.sv
module mode_split_vcache_store #(
    parameter int LINES  = 1024,
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 18,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line
);
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [LINE_W-1:0] line_mem [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
    end

    assign rd_tag  = tag_mem[rd_idx];
    assign rd_line = line_mem[rd_idx];
endmodule

// File: rtl/mode_split_vcache.sv
module mode_split_vcache #(
    parameter int CACHE_BYTES = 16384,
    parameter int LINE_BYTES  = 16,
    parameter int ADDR_W      = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cache_en,
    input  logic                    flush_user,
    input  logic                    flush_super,
    input  logic                    acc_valid,
    input  logic [ADDR_W-1:0]       acc_vaddr,
    input  logic                    acc_super,
    input  logic                    fill_valid,
    input  logic [ADDR_W-1:0]       fill_vaddr,
    input  logic                    fill_super,
    input  logic                    fill_inhibit,
    input  logic [LINE_BYTES*8-1:0] fill_line,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [31:0]             rsp_data
);
    import mode_split_vcache_pkg::*;

    localparam int LINES  = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W  = $clog2(LINES);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORDS  = LINE_BYTES / (WORD_W / 8);
    localparam int WSEL_W = $clog2(WORDS);

    typedef struct packed {
        logic              en_seen;
        logic              vld;
        logic              hit;
        logic [WORD_W-1:0] data;
    } resp_state_t;

    resp_state_t st_d, st_q;

    logic [IDX_W-1:0]  acc_idx, fill_idx;
    logic [TAG_W-1:0]  acc_tag, fill_tag, stored_tag;
    logic [WSEL_W-1:0] acc_wsel;
    logic [LINE_W-1:0] stored_line;
    logic [LINES-1:0]  valid_user, valid_super;
    logic [WORD_W-1:0] line_words [WORDS];
    logic              fill_we, flush_all, mode_valid;
    logic              unused_low_bits;

    assign acc_idx  = acc_vaddr[OFS_W +: IDX_W];
    assign acc_tag  = acc_vaddr[ADDR_W-1 -: TAG_W];
    assign acc_wsel = acc_vaddr[2 +: WSEL_W];
    assign fill_idx = fill_vaddr[OFS_W +: IDX_W];
    assign fill_tag = fill_vaddr[ADDR_W-1 -: TAG_W];
    assign unused_low_bits = ^{acc_vaddr[1:0], fill_vaddr[OFS_W-1:0]};

    assign fill_we   = fill_valid && cache_en && !fill_inhibit;
    assign flush_all = cache_en && !st_q.en_seen;

    mode_split_vcache_valid #(.LINES(LINES), .IDX_W(IDX_W)) u_valid (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_we     (fill_we),
        .fill_idx    (fill_idx),
        .fill_super  (fill_super),
        .flush_user  (flush_user),
        .flush_super (flush_super),
        .flush_all   (flush_all),
        .valid_user  (valid_user),
        .valid_super (valid_super)
    );

    mode_split_vcache_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (fill_we),
        .wr_idx  (fill_idx),
        .wr_tag  (fill_tag),
        .wr_line (fill_line),
        .rd_idx  (acc_idx),
        .rd_tag  (stored_tag),
        .rd_line (stored_line)
    );

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign line_words[w] = stored_line[w*WORD_W +: WORD_W];
    end

    assign mode_valid = (priv_mode_e'(acc_super) == MODE_SUPER) ?
                        valid_super[acc_idx] : valid_user[acc_idx];

    always_comb begin
        st_d         = st_q;
        st_d.en_seen = cache_en;
        st_d.vld     = acc_valid;
        st_d.hit     = acc_valid && cache_en && mode_valid && (stored_tag == acc_tag);
        st_d.data    = st_d.hit ? line_words[acc_wsel] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_hit   = st_q.hit;
    assign rsp_data  = st_q.data;

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    a_r9_disabled_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !cache_en) |=> !rsp_hit);

    a_r6_inhibit_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_inhibit && !flush_user && !flush_super && !flush_all)
        |=> (valid_user == $past(valid_user) && valid_super == $past(valid_super)));

    a_r2_hit_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
endmodule

// File: tb/mode_split_vcache_tb.sv
module mode_split_vcache_tb;
    localparam int CACHE_BYTES = 16384;
    localparam int LINES = CACHE_BYTES / 16;
    localparam int IDX_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cache_en = 1'b0, flush_user = 1'b0, flush_super = 1'b0;
    logic acc_valid = 1'b0, acc_super = 1'b0;
    logic [31:0] acc_vaddr = '0;
    logic fill_valid = 1'b0, fill_super = 1'b0, fill_inhibit = 1'b0;
    logic [31:0] fill_vaddr = '0;
    logic [127:0] fill_line = '0;
    logic rsp_valid, rsp_hit;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;

    bit [LINES-1:0] m_usr, m_sup;
    int unsigned m_tag [LINES];
    logic [127:0] m_line [LINES];
    bit m_en_prev;

    always #10 clk = ~clk;

    mode_split_vcache #(.CACHE_BYTES(CACHE_BYTES)) u_dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .flush_user(flush_user), .flush_super(flush_super),
        .acc_valid(acc_valid), .acc_vaddr(acc_vaddr), .acc_super(acc_super),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_super(fill_super),
        .fill_inhibit(fill_inhibit), .fill_line(fill_line),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] mk_addr(int unsigned tag, int unsigned idx, int unsigned w);
        return (tag << (IDX_W + 4)) | (idx << 4) | (w << 2);
    endfunction

    function automatic logic [127:0] mk_line(int unsigned seed);
        return {seed ^ 32'hD00D0003, seed ^ 32'hC0DE0002, seed ^ 32'hBEEF0001, seed ^ 32'hA5A50000};
    endfunction

    // One clock: model updates at the edge, outputs compared at the next falling edge.
    task automatic step(string req);
        bit e_vld, e_hit;
        logic [31:0] e_data;
        int unsigned ai, fi, at;
        @(posedge clk);
        ai = (acc_vaddr >> 4) % LINES;
        at = acc_vaddr >> (IDX_W + 4);
        e_vld = acc_valid;
        e_hit = acc_valid && cache_en && (acc_super ? m_sup[ai] : m_usr[ai]) && (m_tag[ai] == at);
        e_data = e_hit ? m_line[ai][acc_vaddr[3:2]*32 +: 32] : 32'h0;
        if (fill_valid && cache_en && !fill_inhibit) begin
            fi = (fill_vaddr >> 4) % LINES;
            m_tag[fi] = fill_vaddr >> (IDX_W + 4);
            m_line[fi] = fill_line;
            m_usr[fi] = !fill_super;
            m_sup[fi] = fill_super;
        end
        if ((cache_en && !m_en_prev) || flush_user) m_usr = '0;
        if ((cache_en && !m_en_prev) || flush_super) m_sup = '0;
        m_en_prev = cache_en;
        @(negedge clk);
        checks++;
        if (rsp_valid !== e_vld || rsp_hit !== e_hit || rsp_data !== e_data) begin
            errors++;
            $display("FAIL %s: got vld=%0b hit=%0b data=%h, expected vld=%0b hit=%0b data=%h",
                     req, rsp_valid, rsp_hit, rsp_data, e_vld, e_hit, e_data);
        end
        acc_valid = 1'b0; fill_valid = 1'b0; flush_user = 1'b0; flush_super = 1'b0;
        fill_inhibit = 1'b0;
    endtask

    task automatic look(logic [31:0] a, bit sup, string req);
        acc_valid = 1'b1; acc_vaddr = a; acc_super = sup;
        step(req);
    endtask

    task automatic fill(logic [31:0] a, bit sup, bit inh, int unsigned seed, string req);
        fill_valid = 1'b1; fill_vaddr = a; fill_super = sup; fill_inhibit = inh;
        fill_line = mk_line(seed);
        step(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_usr = '0; m_sup = '0; m_en_prev = 1'b0;
        for (int i = 0; i < LINES; i++) begin m_tag[i] = 0; m_line[i] = '0; end
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
            errors++;
            $display("FAIL R1: got vld=%0b hit=%0b, expected 0 0", rsp_valid, rsp_hit);
        end
        rst_n = 1'b1;
        step("R1");
        cache_en = 1'b1;
        step("R10");
        look(mk_addr(5, 7, 0), 1'b0, "R1");

        // R5/R2/R3: user fill, then word-by-word hits
        fill(mk_addr(5, 7, 0), 1'b0, 1'b0, 32'h100, "R5");
        for (int w = 0; w < 4; w++) look(mk_addr(5, 7, w), 1'b0, "R2");
        look(mk_addr(6, 7, 1), 1'b0, "R3");
        look(mk_addr(5, 7, 2), 1'b1, "R4");

        // R5: supervisor fill at the same index replaces the user line
        fill(mk_addr(9, 7, 0), 1'b1, 1'b0, 32'h200, "R5");
        look(mk_addr(5, 7, 0), 1'b0, "R5");
        look(mk_addr(9, 7, 3), 1'b1, "R5");
        look(mk_addr(9, 7, 3), 1'b0, "R4");

        // R6: inhibited fill
        fill(mk_addr(3, 12, 0), 1'b0, 1'b1, 32'h300, "R6");
        look(mk_addr(3, 12, 0), 1'b0, "R6");

        // R7/R8: selective flushes
        fill(mk_addr(1, 20, 0), 1'b0, 1'b0, 32'h400, "R5");
        fill(mk_addr(2, 21, 0), 1'b1, 1'b0, 32'h500, "R5");
        flush_user = 1'b1; step("R7");
        look(mk_addr(1, 20, 1), 1'b0, "R7");
        look(mk_addr(2, 21, 1), 1'b1, "R7");
        fill(mk_addr(1, 20, 0), 1'b0, 1'b0, 32'h600, "R5");
        flush_super = 1'b1; step("R8");
        look(mk_addr(2, 21, 2), 1'b1, "R8");
        look(mk_addr(1, 20, 2), 1'b0, "R8");

        // R9/R10: disable bypasses, re-enable clears everything
        cache_en = 1'b0;
        look(mk_addr(1, 20, 0), 1'b0, "R9");
        fill(mk_addr(4, 30, 0), 1'b1, 1'b0, 32'h700, "R9");
        cache_en = 1'b1;
        look(mk_addr(1, 20, 0), 1'b0, "R11");
        look(mk_addr(1, 20, 0), 1'b0, "R10");
        look(mk_addr(4, 30, 0), 1'b1, "R9");

        // R11: same-edge ordering
        fill(mk_addr(8, 40, 0), 1'b0, 1'b0, 32'h800, "R5");
        acc_valid = 1'b1; acc_vaddr = mk_addr(8, 40, 1); acc_super = 1'b0;
        fill_valid = 1'b1; fill_vaddr = mk_addr(9, 40, 0); fill_super = 1'b0;
        fill_line = mk_line(32'h900);
        step("R11");
        look(mk_addr(9, 40, 1), 1'b0, "R11");
        fill_valid = 1'b1; fill_vaddr = mk_addr(2, 41, 0); fill_super = 1'b0;
        fill_line = mk_line(32'hA00); flush_user = 1'b1;
        step("R11");
        look(mk_addr(2, 41, 0), 1'b0, "R11");

        // Random mix over a small address set, every cycle compared
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom;
            acc_valid = r[0]; acc_super = r[1];
            acc_vaddr = mk_addr(r[3:2], r[6:4], r[8:7]);
            fill_valid = r[9]; fill_super = r[10]; fill_inhibit = (r[13:11] == 0);
            fill_vaddr = mk_addr(r[15:14], r[18:16], 0);
            fill_line = mk_line(r);
            flush_user = (r[23:19] == 0); flush_super = (r[28:24] == 0);
            if (r[31:29] == 0 && $urandom_range(0, 7) == 0) cache_en = ~cache_en;
            step("R2 random mix");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule